// File: doc/BRIEF.md
# Card Slot Status and Control Registers

This block is a small register file for a board-level memory-card slot. A processor reaches four word-aligned registers over a simple strobe-based read/write bus. The registers are an identification word, a flash-programming register, an interrupt/status register and an address-decode word. The identification and decode words are fixed values.

The block has two level inputs from the card host controller: a write-protect sense and a card-present signal. Each input passes through its own two-flop synchronizer. The status register shows the synchronized write-protect level as a live bit.

A rising edge on the synchronized card-present signal sets a sticky card-inserted flag. That flag drives one level interrupt line to a secondary interrupt controller. Software acknowledges the insertion by writing a 1 to the flag's bit position, and the interrupt drops on the same clock edge.

Top module: `slot_ctrl_regs`

## Requirements
- R1: A read at byte offset 0x0 (register index 0 = byte offset / 4) returns 0x41034003.
- R2: A read at byte offset 0xC (index 3) returns 0x00000011.
- R3: A read at byte offset 0x4 (index 1) returns 0. Writes to index 1 and index 3 change no readable value and do not change the interrupt output.
- R4: Bit 0 of the status register (index 2) follows the write-protect input after two synchronizer flops: 1 when the input is high, 0 when it is low. All bits other than 0 and 3 read as 0.
- R5: Bit 3 of the status register sets on a rising edge of the synchronized card-present input, no later than the third clock edge after the input rises. It stays set after the input falls. It never sets without such an edge.
- R6: A write to index 2 clears bit 3 only when bit 3 of the write data is 1. Bit 0 and a flag written with data bit 3 = 0 are unaffected.
- R7: The interrupt output equals bit 3 of the status register in every cycle, so it falls on the same edge that a clearing write takes effect.
- R8: If a rising card-present edge and a clearing write reach the flag on the same clock edge, the flag stays set and the interrupt stays high.
- R9: Reads at indices above 3 return 0. Writes to them are ignored.
- R10: A synchronous active-high reset clears the flag, the synchronizers and the read data, and drives the interrupt low.
- R11: Read data is registered. It shows the addressed register on the clock edge that samples the read strobe, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| wp_in | input | 1 | Write-protect level from the card host |
| card_in | input | 1 | Card-present level from the card host |
| irq_out | output | 1 | Level interrupt to the secondary interrupt controller |

## Verification
Two events can reach the sticky card flag on one clock edge: a rising edge of the synchronized card-present input, which sets it, and a software write to the status register with bit 3 high, which clears it. The bench lowers the flag first. It then raises the card input and counts the two synchronizer stages so that the clearing write lands on exactly the edge where the rise is detected. The result passes if the interrupt is still high afterwards and bit 3 still reads as 1. A later clearing write with no rise pending must still lower the flag.

// File: rtl/cdreg_pkg.sv
package cdreg_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IDX_ID   = 0;
  localparam int unsigned IDX_FLASH = 1;
  localparam int unsigned IDX_STAT = 2;
  localparam int unsigned IDX_DEC  = 3;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned WP_BIT   = 0;
  localparam int unsigned CI_BIT   = 3;
  localparam logic [DATA_W-1:0] ID_WORD  = 32'h4103_4003;
  localparam logic [DATA_W-1:0] DEC_WORD = 32'h0000_0011;

  typedef enum logic [2:0] {
    SEL_ID, SEL_FLASH, SEL_STAT, SEL_DEC, SEL_NONE
  } reg_sel_e;

  // Word index of a byte offset, widened so out-of-range values stay visible.
  function automatic int unsigned word_index(input logic [31:0] byte_off);
    return int'(byte_off >> 2);
  endfunction

  function automatic reg_sel_e decode_sel(input int unsigned idx);
    case (idx)
      IDX_ID:    return SEL_ID;
      IDX_FLASH: return SEL_FLASH;
      IDX_STAT:  return SEL_STAT;
      IDX_DEC:   return SEL_DEC;
      default:   return SEL_NONE;
    endcase
  endfunction

  // Status word layout: write-protect level and sticky insert flag.
  function automatic logic [DATA_W-1:0] status_word(input logic wp, input logic ins);
    logic [DATA_W-1:0] w;
    w = '0;
    w[WP_BIT] = wp;
    w[CI_BIT] = ins;
    return w;
  endfunction

  // Next flag value: a detected rise wins over a write-one-to-clear.
  function automatic logic next_flag(input logic cur, input logic rise, input logic clr);
    return rise | (cur & ~clr);
  endfunction
endpackage

// File: rtl/cdreg_sync.sv
module cdreg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/cdreg_status.sv
module cdreg_status (
  input  logic clk,
  input  logic rst,
  input  logic card_sync,
  input  logic clr_evt,
  output logic rise_evt,
  output logic flag
);
  import cdreg_pkg::*;

  logic card_prev;

  always_ff @(posedge clk) begin
    if (rst) card_prev <= 1'b0;
    else     card_prev <= card_sync;
  end

  assign rise_evt = card_sync & ~card_prev;

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= next_flag(flag, rise_evt, clr_evt);
  end
endmodule

// File: rtl/cdreg_rdmux.sv
module cdreg_rdmux (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  cdreg_pkg::reg_sel_e          sel,
  input  logic                         wp_sync,
  input  logic                         flag,
  output logic [cdreg_pkg::DATA_W-1:0] rdata
);
  import cdreg_pkg::*;

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    case (sel)
      SEL_ID:    rd_next = ID_WORD;
      SEL_FLASH: rd_next = '0;
      SEL_STAT:  rd_next = status_word(wp_sync, flag);
      SEL_DEC:   rd_next = DEC_WORD;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/slot_ctrl_regs.sv
module slot_ctrl_regs #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              wp_in,
  input  logic              card_in,
  output logic              irq_out
);
  import cdreg_pkg::*;

  logic [31:0] addr_ext;
  reg_sel_e    sel;
  logic        wp_sync;
  logic        card_sync;
  logic        clr_evt;
  logic        rise_evt;
  logic        flag;

  assign addr_ext = 32'(addr);
  assign sel      = decode_sel(word_index(addr_ext));
  // Only the status register has a writable effect: write-one-to-clear on the flag bit.
  assign clr_evt  = wr_en & (sel == SEL_STAT) & wdata[CI_BIT];

  cdreg_sync #(.STAGES(SYNC_STAGES)) u_wp_sync (
    .clk(clk), .rst(rst), .d_in(wp_in), .q_out(wp_sync)
  );

  cdreg_sync #(.STAGES(SYNC_STAGES)) u_card_sync (
    .clk(clk), .rst(rst), .d_in(card_in), .q_out(card_sync)
  );

  cdreg_status u_status (
    .clk(clk), .rst(rst), .card_sync(card_sync), .clr_evt(clr_evt),
    .rise_evt(rise_evt), .flag(flag)
  );

  cdreg_rdmux u_rdmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel),
    .wp_sync(wp_sync), .flag(flag), .rdata(rdata)
  );

  assign irq_out = flag;
endmodule

// File: rtl/cdreg_chk.sv
module cdreg_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              irq_out,
  input logic              rise_evt,
  input logic              clr_evt
);
  logic [ADDR_W-3:0] idx;
  assign idx = addr[ADDR_W-1:2];

  // R1
  p_id_read_r1: assert property (@(posedge clk) disable iff (rst)
    rd_en && idx == 0 |=> rdata == 32'h4103_4003);
  // R9
  p_oob_read_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en && idx > 3 |=> rdata == 32'h0);
  // R5
  p_rise_sets_r5: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> irq_out);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    !irq_out && !rise_evt |=> !irq_out);
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    irq_out && !clr_evt |=> irq_out);
  // R6
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr_evt && !rise_evt |=> !irq_out);
  // R8
  p_collide_r8: assert property (@(posedge clk) disable iff (rst)
    clr_evt && rise_evt |=> irq_out);
  // R7
  p_irq_matches_status_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en && idx == 2 |=> rdata[3] == $past(irq_out));
  // R10
  p_reset_r10: assert property (@(posedge clk)
    rst |=> !irq_out && rdata == 32'h0);
endmodule

bind slot_ctrl_regs cdreg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq_out(irq_out), .rise_evt(rise_evt), .clr_evt(clr_evt)
);

// File: tb/sim_slot_ctrl_regs.sv
module sim_slot_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wp_in = 1'b0;
  logic        card_in = 1'b0;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam logic [31:0] EXP_ID  = 32'h4103_4003;
  localparam logic [31:0] EXP_DEC = 32'h0000_0011;

  always #5 clk = ~clk;

  slot_ctrl_regs u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wp_in(wp_in), .card_in(card_in),
    .irq_out(irq_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired got=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  function automatic logic [31:0] exp_status(input logic wp, input logic ins);
    return (32'(ins) << 3) | 32'(wp);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 rdata after reset", rdata, 32'h0);
    check("R10 irq after reset", 32'(irq_out), 32'h0);
  endtask

  task automatic t_fixed;
    logic [31:0] d;
    rd(8'h00, d); check("R1 id word", d, EXP_ID);
    rd(8'h0C, d); check("R2 decode word", d, EXP_DEC);
    rd(8'h04, d); check("R3 flash reads zero", d, 32'h0);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    rd(8'h04, d);
    @(negedge clk);
    rd_en = 1'b1; addr = 8'h00;
    #2 check("R11 data not yet updated", rdata, 32'h0);
    @(negedge clk);
    rd_en = 1'b0; addr = 8'h0C;
    check("R11 data one cycle after strobe", rdata, EXP_ID);
    idle(2);
    check("R11 data held without strobe", rdata, EXP_ID);
  endtask

  task automatic t_wp;
    logic [31:0] d;
    wp_in = 1'b1; idle(4);
    rd(8'h08, d); check("R4 wp high", d, exp_status(1'b1, 1'b0));
    wp_in = 1'b0; idle(4);
    rd(8'h08, d); check("R4 wp low", d, exp_status(1'b0, 1'b0));
  endtask

  task automatic t_insert;
    logic [31:0] d;
    @(negedge clk); card_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R5 flag not before detection", 32'(irq_out), 32'h0);
    @(negedge clk);
    check("R5 flag on third edge", 32'(irq_out), 32'h1);
    card_in = 1'b0; idle(4);
    rd(8'h08, d); check("R5 flag sticky after input falls", d, exp_status(1'b0, 1'b1));
    check("R7 irq while flag set", 32'(irq_out), 32'h1);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wp_in = 1'b1; idle(4);
    wr(8'h08, 32'hFFFF_FFF7);
    rd(8'h08, d); check("R6 write without bit3 keeps flag", d, exp_status(1'b1, 1'b1));
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    check("R3 irq after flash/decode writes", 32'(irq_out), 32'h1);
    rd(8'h04, d); check("R3 flash still zero", d, 32'h0);
    rd(8'h0C, d); check("R3 decode unchanged", d, EXP_DEC);
    rd(8'h08, d); check("R3 status unchanged", d, exp_status(1'b1, 1'b1));
    wr(8'h10, 32'h0000_0008);
    wr(8'hFC, 32'h0000_0008);
    check("R9 oob write ignored", 32'(irq_out), 32'h1);
    rd(8'h10, d); check("R9 oob read zero", d, 32'h0);
    rd(8'hFC, d); check("R9 top oob read zero", d, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h08; wdata = 32'h0000_0008;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 irq drops on clearing edge", 32'(irq_out), 32'h0);
    rd(8'h08, d); check("R6 clear keeps wp bit", d, exp_status(1'b1, 1'b0));
    wp_in = 1'b0; idle(4);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk); card_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h08; wdata = 32'h0000_0008;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 rise beats clear", 32'(irq_out), 32'h1);
    rd(8'h08, d); check("R8 status flag kept", d, exp_status(1'b0, 1'b1));
    wr(8'h08, 32'h0000_0008);
    check("R6 later clear works", 32'(irq_out), 32'h0);
    idle(4);
    check("R5 no set while input stays high", 32'(irq_out), 32'h0);
    card_in = 1'b0; idle(4);
  endtask

  task automatic t_reset_mid;
    @(negedge clk); card_in = 1'b1; idle(5);
    check("R5 set before reset", 32'(irq_out), 32'h1);
    rst = 1'b1; card_in = 1'b0;
    @(negedge clk);
    check("R10 reset clears irq", 32'(irq_out), 32'h0);
    rst = 1'b0; idle(4);
    check("R10 stays clear after reset", 32'(irq_out), 32'h0);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst = 1'b0;
    t_fixed();
    t_latency();
    t_wp();
    t_insert();
    t_clear();
    t_collide();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule